// File: doc/BRIEF.md
# Bidirectional double data rate pin interface

This block owns a group of shared data pins and moves two bits per pin in every period of a single clock, one in each clock phase. On the receive side each pin is sampled on the rising edge and again on the falling edge. The two samples are moved into the rising-edge domain and presented together as a high/low pair. On the transmit side a high-half word and a low-half word are registered on the rising edge. The level of the clock then picks which of the two drives the pins: the high half while the clock is high, the low half while it is low.

A write-enable input, registered with the transmit data, controls a tri-state driver. The pins can therefore be handed to an external device and back at clock-period boundaries. Throughput per pin is twice that of a single-data-rate link at the same clock frequency. The lane count is a parameter.

Top module: `ddr_bidir_io`

## Requirements
- R1: While the registered enable is set, each pin carries the bit of `tx_hi` sampled at the most recent rising edge for the whole of the clock-high phase that follows that edge.
- R2: While the registered enable is set, each pin carries the bit of `tx_lo` sampled at the most recent rising edge for the whole of the clock-low phase that follows the high phase.
- R3: `tx_wen`, `tx_hi` and `tx_lo` are sampled only on rising edges. A change between edges has no effect on the pins. The driver turns on at the rising edge after `tx_wen` is seen high, and the first driven phase carries the high half registered at that same edge.
- R4: When `tx_wen` was low at the last rising edge, the block does not drive the pins, so an external driver sets their value without contention in both phases, whatever `tx_hi` and `tx_lo` hold.
- R5: The pin value sampled at rising edge E appears on `rx_hi` right after rising edge E+1.
- R6: The pin value sampled at the falling edge between E and E+1 appears on `rx_lo` right after rising edge E+1, in the same cycle as the R5 bit of edge E.
- R7: `rx_hi` and `rx_lo` change only at rising edges and hold their value across falling edges.
- R8: Reset is synchronous and active low. While it is applied, all data and enable registers clear, the pins are not driven even when `tx_wen` is high, and `rx_hi` and `rx_lo` read zero from the edge after it is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock; its level also selects the transmitted half |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_wen | input | 1 | Drive request, sampled on the rising edge |
| tx_hi | input | LANES | Bits to send during the clock-high phase |
| tx_lo | input | LANES | Bits to send during the clock-low phase |
| rx_hi | output | LANES | Rising-edge samples, retimed one cycle |
| rx_lo | output | LANES | Falling-edge samples, retimed to the rising edge |
| ddr_pad | inout | LANES | Shared bidirectional data pins |

## Verification
Suppose a rising-edge or falling-edge capture register holds the wrong value. The received pair then differs from what the external model drove, one rising edge after the falling-edge capture, and the scoreboard compares the pair at that edge. Suppose the two transmit registers are swapped or mis-timed. The wrong word then appears in the very next clock phase, and the pin is sampled in the middle of every phase. A stuck or mis-registered enable shows at once as a mix of the block's all-ones idle data with the external pattern while the external device owns the pins, or as a missing first high half after turnaround.

// File: rtl/ddr_bidir_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the bidirectional double data rate pin block.
// Assumes: nothing beyond the standard language.
package ddr_bidir_pkg;

    // Lane count used when the top is elaborated with defaults.
    localparam int unsigned DDR_LANES_DEFAULT = 4;

    // Which half of the clock period is on the pins.
    typedef enum logic {
        HALF_LOW  = 1'b0,
        HALF_HIGH = 1'b1
    } ddr_half_e;

endpackage

// File: rtl/ddr_rx_capture.sv
`timescale 1ns/1ps
// Receive path: samples the pins on both clock edges and presents each
// period's two samples together, aligned to the rising edge.
// Assumes: pin data is stable around both clock edges; one clock domain.
module ddr_rx_capture #(
    parameter int unsigned LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] pin_in,
    output logic [LANES-1:0] pair_hi,
    output logic [LANES-1:0] pair_lo
);

    logic [LANES-1:0] rise_q;
    logic [LANES-1:0] fall_q;

    // Rising-edge capture of the pins.
    always_ff @(posedge clk) begin
        if (!rst_n) rise_q <= '0;
        else        rise_q <= pin_in;
    end

    // Falling-edge capture of the pins (inverted-clock register).
    always_ff @(negedge clk) begin
        if (!rst_n) fall_q <= '0;
        else        fall_q <= pin_in;
    end

    // Retime both samples onto the rising edge as one pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pair_hi <= '0;
            pair_lo <= '0;
        end else begin
            pair_hi <= rise_q;
            pair_lo <= fall_q;
        end
    end

    AST_RST_RX_CLEAR: assert property (@(posedge clk) !rst_n |=> (pair_hi == '0 && pair_lo == '0)); // R8

endmodule

// File: rtl/ddr_tx_launch.sv
`timescale 1ns/1ps
// Transmit registers: holds the high-half word, the low-half word and
// the drive enable, all loaded on the rising edge.
// Assumes: inputs settle before each rising edge.
module ddr_tx_launch #(
    parameter int unsigned LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wen_in,
    input  logic [LANES-1:0] hi_in,
    input  logic [LANES-1:0] lo_in,
    output logic [LANES-1:0] hi_q,
    output logic [LANES-1:0] lo_q,
    output logic             drive_q
);

    // Register both halves of the outgoing word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            hi_q <= hi_in;
            lo_q <= lo_in;
        end
    end

    // Register the drive request so turnaround happens at cycle boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) drive_q <= 1'b0;
        else        drive_q <= wen_in;
    end

    AST_RST_PIN_RELEASE: assert property (@(posedge clk) !rst_n |=> !drive_q); // R8
    AST_DRIVE_ON_NEEDS_WEN: assert property (@(posedge clk) disable iff (!rst_n) $rose(drive_q) |-> $past(wen_in)); // R3
    AST_DRIVE_OFF_NEEDS_NO_WEN: assert property (@(posedge clk) disable iff (!rst_n) $fell(drive_q) |-> (!$past(wen_in) || !$past(rst_n))); // R4

endmodule

// File: rtl/ddr_phase_mux.sv
`timescale 1ns/1ps
// Clock-phase selector: passes the high half while the clock is high and
// the low half while it is low, one 2:1 selector per lane.
// Assumes: the select is the same clock that loads the transmit registers.
module ddr_phase_mux
    import ddr_bidir_pkg::*;
#(
    parameter int unsigned LANES = 4
) (
    input  logic             clk_level,
    input  logic [LANES-1:0] hi_bits,
    input  logic [LANES-1:0] lo_bits,
    output logic [LANES-1:0] pin_bits
);

    ddr_half_e half;

    // Decode the clock level into the active half.
    always_comb begin
        half = clk_level ? HALF_HIGH : HALF_LOW;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign pin_bits[g] = (half == HALF_HIGH) ? hi_bits[g] : lo_bits[g];
    end

endmodule

// File: rtl/ddr_bidir_io.sv
`timescale 1ns/1ps
// Bidirectional double data rate pin interface. Sends two bits per pin
// per clock period when enabled and always receives two bits per pin
// per period, presented as a rising-edge-aligned pair.
// Assumes: single clock; the external device drives only while the
// registered enable is low.
module ddr_bidir_io
    import ddr_bidir_pkg::*;
#(
    parameter int unsigned LANES = DDR_LANES_DEFAULT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_wen,
    input  logic [LANES-1:0] tx_hi,
    input  logic [LANES-1:0] tx_lo,
    output logic [LANES-1:0] rx_hi,
    output logic [LANES-1:0] rx_lo,
    inout  wire  [LANES-1:0] ddr_pad
);

    logic [LANES-1:0] hi_q;
    logic [LANES-1:0] lo_q;
    logic             drive_en;
    logic [LANES-1:0] pad_bits;

    ddr_tx_launch #(.LANES(LANES)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .wen_in  (tx_wen),
        .hi_in   (tx_hi),
        .lo_in   (tx_lo),
        .hi_q    (hi_q),
        .lo_q    (lo_q),
        .drive_q (drive_en)
    );

    ddr_phase_mux #(.LANES(LANES)) u_mux (
        .clk_level (clk),
        .hi_bits   (hi_q),
        .lo_bits   (lo_q),
        .pin_bits  (pad_bits)
    );

    // Tri-state driver per lane, enabled by the registered request.
    for (genvar g = 0; g < LANES; g++) begin : g_pad
        assign ddr_pad[g] = drive_en ? pad_bits[g] : 1'bz;
    end

    ddr_rx_capture #(.LANES(LANES)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_in  (ddr_pad),
        .pair_hi (rx_hi),
        .pair_lo (rx_lo)
    );

    AST_RX_HI_FROM_PIN: assert property (@(posedge clk) disable iff (!rst_n) ($past(rst_n) && $past(rst_n, 2) && !$past(drive_en) && !$past(drive_en, 2)) |-> (rx_hi === $past(ddr_pad, 2))); // R5

endmodule

// File: tb/ddr_bidir_io_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected pin and receive values;
// monitors sample mid-phase and compare.
module ddr_bidir_io_tb;

    localparam int W = 4;

    typedef struct {
        int         due;
        logic [W-1:0] h;
        logic [W-1:0] l;
        bit         first;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tx_wen = 1'b1;
    logic [W-1:0] tx_hi = '1;
    logic [W-1:0] tx_lo = '1;
    logic [W-1:0] rx_hi;
    logic [W-1:0] rx_lo;
    logic         ext_en = 1'b1;
    logic [W-1:0] ext_val = '0;
    wire  [W-1:0] ddr_pad;

    int n_checks = 0;
    int n_fail = 0;
    int edge_n = 0;
    bit done = 1'b0;
    logic [W-1:0] rx_hi_seen = '0;
    logic [W-1:0] rx_lo_seen = '0;
    item_t tx_q[$];
    item_t rx_q[$];

    assign ddr_pad = ext_en ? ext_val : 'z;

    ddr_bidir_io #(.LANES(W)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_wen  (tx_wen),
        .tx_hi   (tx_hi),
        .tx_lo   (tx_lo),
        .rx_hi   (rx_hi),
        .rx_lo   (rx_lo),
        .ddr_pad (ddr_pad)
    );

    always #5 clk = ~clk;

    always @(posedge clk) edge_n <= edge_n + 1;

    task automatic check(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Monitor for the high phase and the receive pair.
    always @(posedge clk) begin
        #3;
        if (ext_en) check(rst_n ? "R4" : "R8", "pin held by external device (high phase)", ddr_pad, ext_val);
        if (tx_q.size() > 0 && tx_q[0].due == edge_n)
            check(tx_q[0].first ? "R3" : "R1", "high-phase pin value", ddr_pad, tx_q[0].h);
        if (rx_q.size() > 0 && rx_q[0].due == edge_n) begin
            check("R5", "rx_hi pair bit", rx_hi, rx_q[0].h);
            check("R6", "rx_lo pair bit", rx_lo, rx_q[0].l);
            void'(rx_q.pop_front());
        end
        if (!rst_n) begin
            check("R8", "rx_hi in reset", rx_hi, '0);
            check("R8", "rx_lo in reset", rx_lo, '0);
        end
        rx_hi_seen = rx_hi;
        rx_lo_seen = rx_lo;
    end

    // Monitor for the low phase and receive stability across falling edges.
    always @(negedge clk) begin
        #3;
        if (ext_en) check(rst_n ? "R4" : "R8", "pin held by external device (low phase)", ddr_pad, ext_val);
        if (tx_q.size() > 0 && tx_q[0].due == edge_n) begin
            check("R2", "low-phase pin value", ddr_pad, tx_q[0].l);
            void'(tx_q.pop_front());
        end
        check("R7", "rx_hi across falling edge", rx_hi, rx_hi_seen);
        check("R7", "rx_lo across falling edge", rx_lo, rx_lo_seen);
    end

    task automatic ext_send(logic [W-1:0] a, logic [W-1:0] b);
        item_t it;
        @(negedge clk); #2;
        ext_en = 1'b1;
        ext_val = a;
        @(posedge clk); #2;
        ext_val = b;
        it.due = edge_n + 1; it.h = a; it.l = b; it.first = 1'b0;
        rx_q.push_back(it);
    endtask

    task automatic tx_send(logic [W-1:0] h, logic [W-1:0] l, bit first, bit glitch);
        item_t it;
        @(negedge clk); #2;
        tx_wen = 1'b1;
        tx_hi = h;
        tx_lo = l;
        it.due = edge_n + 1; it.h = h; it.l = l; it.first = first;
        tx_q.push_back(it);
        if (glitch) begin
            @(posedge clk); #1;
            tx_hi = ~h;
            tx_lo = ~l;
        end
    endtask

    task automatic to_tx();
        @(negedge clk); #2;
        ext_en = 1'b0;
    endtask

    task automatic to_rx();
        @(negedge clk); #2;
        tx_wen = 1'b0;
        tx_hi = '1;
        tx_lo = '1;
        @(posedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung run expected completion");
            finish_run();
        end
    end

    initial begin
        // R8: reset held with drive requested; external zeros must win.
        repeat (4) @(posedge clk);
        @(negedge clk); #2;
        tx_wen = 1'b0;
        rst_n = 1'b1;

        // R5/R6: external device drives pairs; tx data all ones is ignored (R4).
        ext_send(4'h5, 4'hA);
        ext_send(4'hF, 4'h0);
        ext_send(4'h0, 4'hF);
        ext_send(4'h3, 4'hC);
        for (int i = 0; i < 8; i++) ext_send(W'(i * 5 + 1), W'(~(i * 3)));

        // Turnaround to transmit; first item checks enable alignment (R3).
        to_tx();
        for (int i = 0; i < 6; i++) tx_send(W'(i * 7 + 2), W'(i * 11 + 5), i == 0, 1'b0);
        tx_send(4'h9, 4'h6, 1'b0, 1'b1);
        tx_send(4'h0, 4'hF, 1'b0, 1'b0);
        tx_send(4'hA, 4'h5, 1'b0, 1'b1);

        // Turnaround back to receive.
        to_rx();
        ext_send(4'h0, 4'h0);
        ext_send(4'h8, 4'h1);
        for (int i = 0; i < 4; i++) ext_send(W'(i * 9), W'(i * 4 + 2));

        repeat (4) @(posedge clk);
        #4;
        n_checks++;
        if (rx_q.size() != 0 || tx_q.size() != 0) begin
            n_fail++;
            $display("FAIL R5 scoreboard drained: actual %0d/%0d left expected 0/0", rx_q.size(), tx_q.size());
        end
        done = 1'b1;
        finish_run();
    end

endmodule